// File: doc/BRIEF.md
# Dual-lane saturating add-subtract ALU

This block is a SIMD arithmetic unit that takes an opcode and two 32-bit operands and returns a 64-bit result one clock later. Its main operation produces the sum and the difference of the same operand pair in one step. The lower result word holds the sum and the upper word holds the difference. The pair is computed either on whole 32-bit values or on two independent 16-bit lanes. Each form comes in a wrapping variant and a signed saturating variant.

The same unit also handles the lane-shuffling operations that feed and drain packed arithmetic. It gives the per-lane signed minimum and maximum of two packed operands. It widens a pair of bytes into two 16-bit lanes, with zero or sign extension. It narrows values back into bytes or 16-bit lanes, clamping them to the target range. A flag vector reports every lane that was clamped. Operands and opcode are captured on each rising clock edge, so a new operation can start every cycle.

Top module: `dual_lane_alu`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, `result` and `sat_flags` are zero. Every result and flag vector appears on the outputs one clock edge after its opcode and operands are sampled.
- R2: Opcode 0 (wrapping word pair) gives `result[31:0] = a + b` and `result[63:32] = a - b`, both modulo 2^32, and all flags are zero.
- R3: Opcode 1 (saturating word pair) computes the same pair as signed 32-bit values. A sum that overflows becomes 0x7FFFFFFF (positive) or 0x80000000 (negative) and sets `sat_flags[0]`. A difference that overflows is clamped the same way and sets `sat_flags[2]`.
- R4: Opcode 2 (wrapping lane pair) computes, for each 16-bit lane i, the lane sum into `result[16i+15:16i]` and the lane difference into `result[32+16i+15:32+16i]`. Both wrap modulo 2^16, no carry or borrow passes between lanes, and all flags are zero.
- R5: Opcode 3 (saturating lane pair) clamps each signed 16-bit lane result to 0x7FFF or 0x8000. A clamped sum in lane i sets `sat_flags[i]`, and a clamped difference in lane i sets `sat_flags[2+i]`.
- R6: Opcode 4 puts the signed minimum of each lane pair into the lower word and the signed maximum into the upper word, in the same lane position. Flags are zero.
- R7: Opcodes 5 to 8 widen two bytes of `src_a` into the lower word and the same two bytes of `src_b` into the upper word. Byte j of the chosen half goes to lane j. Opcodes 5 and 6 choose bits 15:0, and opcodes 7 and 8 choose bits 31:16. Opcodes 5 and 7 zero-extend, and opcodes 6 and 8 sign-extend. Flags are zero.
- R8: Opcode 9 narrows the four signed 16-bit lanes to unsigned bytes in the lower word. Byte 0 comes from a.lane0, byte 1 from a.lane1, byte 2 from b.lane0 and byte 3 from b.lane1. Negative values become 0x00 and values above 255 become 0xFF, and either case sets `sat_flags[k]` for byte k. The upper word is zero.
- R9: Opcode 10 narrows signed 32-bit `src_a` into lane 0 and signed 32-bit `src_b` into lane 1 of the lower word. Each value is clamped to 0x7FFF or 0x8000, and a clamp sets `sat_flags[0]` for a and `sat_flags[1]` for b. The upper word is zero.
- R10: Opcodes 11 to 15 are undefined and give a zero result with zero flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 4 | Operation select |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| result | output | 64 | Lower word: sum, minimum or narrowed data. Upper word: difference, maximum or widened `src_b` |
| sat_flags | output | 4 | Per-lane clamp indicators |

## Verification
Each 16-bit half of each operand is swept over eight values: 0, 1, 0x007F, 0x0080, 0x00FF, 0x7FFF, 0x8000 and 0xFFFF. All 4096 operand combinations are applied under every defined opcode and one undefined opcode. The lane extremes separate wrapping from clamping and show whether a clamp goes to the correct rail. Mixing 0xFFFF and 0x0001 across the lane boundary shows up any carry that leaks between lanes. The byte-edge values 0x007F, 0x0080 and 0x00FF tell zero extension from sign extension when unpacking, and they show the clamp points of the unsigned byte pack.

// File: rtl/dlalu_pkg.sv
// Package: shared opcode encoding for the dual-lane add-subtract ALU.
// Assumes a 4-bit opcode field; codes above OP_PACK_S16 are undefined.
package dlalu_pkg;

    typedef enum logic [3:0] {
        OP_AS_WORD      = 4'd0,
        OP_AS_WORD_SAT  = 4'd1,
        OP_AS_LANE      = 4'd2,
        OP_AS_LANE_SAT  = 4'd3,
        OP_MINMAX       = 4'd4,
        OP_WIDEN_LO_Z   = 4'd5,
        OP_WIDEN_LO_S   = 4'd6,
        OP_WIDEN_HI_Z   = 4'd7,
        OP_WIDEN_HI_S   = 4'd8,
        OP_PACK_U8      = 4'd9,
        OP_PACK_S16     = 4'd10
    } dlalu_op_e;

endpackage

// File: rtl/dlalu_sat_addsub.sv
// Module: dlalu_sat_addsub
// Computes sum and difference of one signed pair of width W at the same
// time. When sat_en is high, an overflowing result is clamped to the signed
// rail and the matching clip output is raised. Purely combinational.
module dlalu_sat_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sat_en,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         sum_clip,
    output logic         diff_clip
);

    localparam logic [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

    logic [W:0] s_ext;
    logic [W:0] d_ext;
    logic       s_ovf;
    logic       d_ovf;

    // One extra sign bit holds the exact result; top two bits differ on overflow.
    assign s_ext = {x[W-1], x} + {y[W-1], y};
    assign d_ext = {x[W-1], x} - {y[W-1], y};
    assign s_ovf = s_ext[W] ^ s_ext[W-1];
    assign d_ovf = d_ext[W] ^ d_ext[W-1];

    // Choose wrapped or clamped value for each result.
    always_comb begin
        sum       = s_ext[W-1:0];
        diff      = d_ext[W-1:0];
        sum_clip  = sat_en & s_ovf;
        diff_clip = sat_en & d_ovf;
        if (sum_clip)  sum  = s_ext[W] ? NEG_RAIL : POS_RAIL;
        if (diff_clip) diff = d_ext[W] ? NEG_RAIL : POS_RAIL;
    end

endmodule

// File: rtl/dlalu_minmax.sv
// Module: dlalu_minmax
// Per-lane signed minimum and maximum of two packed words. Assumes lanes of
// LANE_W bits, lane 0 in the least significant position. Combinational.
module dlalu_minmax #(
    parameter int LANE_W    = 16,
    parameter int NUM_LANES = 2
) (
    input  logic [LANE_W*NUM_LANES-1:0] a,
    input  logic [LANE_W*NUM_LANES-1:0] b,
    output logic [LANE_W*NUM_LANES-1:0] lo_word,
    output logic [LANE_W*NUM_LANES-1:0] hi_word
);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] xa;
        logic [LANE_W-1:0] xb;
        logic              a_less;

        assign xa = a[i*LANE_W +: LANE_W];
        assign xb = b[i*LANE_W +: LANE_W];

        // Signed compare picks which operand is the smaller one.
        assign a_less = $signed(xa) < $signed(xb);
        assign lo_word[i*LANE_W +: LANE_W] = a_less ? xa : xb;
        assign hi_word[i*LANE_W +: LANE_W] = a_less ? xb : xa;
    end

endmodule

// File: rtl/dlalu_widen.sv
// Module: dlalu_widen
// Takes one half of a word (NUM_LANES bytes) and widens byte j into lane j,
// with zero or sign extension. Assumes LANE_W is even (byte = LANE_W/2).
module dlalu_widen #(
    parameter int LANE_W    = 16,
    parameter int NUM_LANES = 2
) (
    input  logic [LANE_W*NUM_LANES-1:0] src,
    input  logic                        hi_sel,
    input  logic                        sx,
    output logic [LANE_W*NUM_LANES-1:0] word
);

    localparam int WORD_W = LANE_W * NUM_LANES;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = LANE_W / 2;

    logic [HALF_W-1:0] half;

    // Select the byte group that gets widened.
    assign half = hi_sel ? src[WORD_W-1:HALF_W] : src[HALF_W-1:0];

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] bt;
        assign bt = half[i*BYTE_W +: BYTE_W];
        // Fill the upper byte with zeros or copies of the byte's sign bit.
        assign word[i*LANE_W +: LANE_W] = {{BYTE_W{sx & bt[BYTE_W-1]}}, bt};
    end

endmodule

// File: rtl/dlalu_narrow.sv
// Module: dlalu_narrow
// Two saturating narrowing paths. The first packs all signed lanes of a then
// b into unsigned bytes. The second packs signed whole words a and b into
// signed lanes 0 and 1. Assumes NUM_LANES >= 2; lanes above 1 of the second
// path are zero.
module dlalu_narrow #(
    parameter int LANE_W    = 16,
    parameter int NUM_LANES = 2
) (
    input  logic [LANE_W*NUM_LANES-1:0] a,
    input  logic [LANE_W*NUM_LANES-1:0] b,
    output logic [LANE_W*NUM_LANES-1:0] u8_word,
    output logic [2*NUM_LANES-1:0]      u8_clip,
    output logic [LANE_W*NUM_LANES-1:0] s_word,
    output logic [NUM_LANES-1:0]        s_clip
);

    localparam int WORD_W   = LANE_W * NUM_LANES;
    localparam int BYTE_W   = LANE_W / 2;
    localparam int HIGH_W   = WORD_W - LANE_W + 1;
    localparam logic [LANE_W-1:0] POS_RAIL = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_RAIL = {1'b1, {(LANE_W-1){1'b0}}};

    // Signed lane to unsigned byte, one per byte slot of the output word.
    for (genvar k = 0; k < 2*NUM_LANES; k++) begin : g_byte
        logic [LANE_W-1:0] ln;
        logic              neg;
        logic              big;

        if (k < NUM_LANES) begin : g_from_a
            assign ln = a[k*LANE_W +: LANE_W];
        end else begin : g_from_b
            assign ln = b[(k-NUM_LANES)*LANE_W +: LANE_W];
        end

        assign neg = ln[LANE_W-1];
        assign big = ~neg & (|ln[LANE_W-2:BYTE_W]);
        assign u8_word[k*BYTE_W +: BYTE_W] = neg ? '0 : (big ? '1 : ln[BYTE_W-1:0]);
        assign u8_clip[k] = neg | big;
    end

    // Signed word to signed lane: it fits only when the discarded bits equal the lane sign.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if (i < 2) begin : g_src
            logic [WORD_W-1:0] wd;
            logic [HIGH_W-1:0] top;
            logic              fits;

            assign wd   = (i == 0) ? a : b;
            assign top  = wd[WORD_W-1:LANE_W-1];
            assign fits = (&top) | ~(|top);
            assign s_word[i*LANE_W +: LANE_W] = fits ? wd[LANE_W-1:0]
                                              : (wd[WORD_W-1] ? NEG_RAIL : POS_RAIL);
            assign s_clip[i] = ~fits;
        end else begin : g_none
            assign s_word[i*LANE_W +: LANE_W] = '0;
            assign s_clip[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dual_lane_alu.sv
// Module: dual_lane_alu (top)
// Dual-lane saturating add-subtract ALU. It decodes the opcode, runs the
// word and lane add/subtract paths, min/max, widen and narrow, and registers
// the selected 64-bit result and clip flags. Assumes synchronous active-low
// reset and a new operation on every clock.
module dual_lane_alu #(
    parameter int LANE_W    = 16,
    parameter int NUM_LANES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [3:0]                    op_code,
    input  logic [LANE_W*NUM_LANES-1:0]   src_a,
    input  logic [LANE_W*NUM_LANES-1:0]   src_b,
    output logic [2*LANE_W*NUM_LANES-1:0] result,
    output logic [2*NUM_LANES-1:0]        sat_flags
);

    import dlalu_pkg::*;

    localparam int WORD_W = LANE_W * NUM_LANES;
    localparam int FLAG_W = 2 * NUM_LANES;

    dlalu_op_e op;
    logic      word_sat;
    logic      lane_sat;
    logic      widen_hi;
    logic      widen_sx;

    // Opcode decode into path controls.
    assign op       = dlalu_op_e'(op_code);
    assign word_sat = (op == OP_AS_WORD_SAT);
    assign lane_sat = (op == OP_AS_LANE_SAT);
    assign widen_hi = (op == OP_WIDEN_HI_Z) || (op == OP_WIDEN_HI_S);
    assign widen_sx = (op == OP_WIDEN_LO_S) || (op == OP_WIDEN_HI_S);

    // Whole-word add/subtract pair.
    logic [WORD_W-1:0] w_sum;
    logic [WORD_W-1:0] w_diff;
    logic              w_sclip;
    logic              w_dclip;

    dlalu_sat_addsub #(.W(WORD_W)) u_word (
        .x         (src_a),
        .y         (src_b),
        .sat_en    (word_sat),
        .sum       (w_sum),
        .diff      (w_diff),
        .sum_clip  (w_sclip),
        .diff_clip (w_dclip)
    );

    // Per-lane add/subtract pairs, one independent instance per lane.
    logic [WORD_W-1:0]    l_sum;
    logic [WORD_W-1:0]    l_diff;
    logic [NUM_LANES-1:0] l_sclip;
    logic [NUM_LANES-1:0] l_dclip;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_as
        dlalu_sat_addsub #(.W(LANE_W)) u_lane (
            .x         (src_a[i*LANE_W +: LANE_W]),
            .y         (src_b[i*LANE_W +: LANE_W]),
            .sat_en    (lane_sat),
            .sum       (l_sum[i*LANE_W +: LANE_W]),
            .diff      (l_diff[i*LANE_W +: LANE_W]),
            .sum_clip  (l_sclip[i]),
            .diff_clip (l_dclip[i])
        );
    end

    // Lane minimum and maximum.
    logic [WORD_W-1:0] mm_min;
    logic [WORD_W-1:0] mm_max;

    dlalu_minmax #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_minmax (
        .a       (src_a),
        .b       (src_b),
        .lo_word (mm_min),
        .hi_word (mm_max)
    );

    // Byte widening of each operand.
    logic [WORD_W-1:0] wd_a;
    logic [WORD_W-1:0] wd_b;

    dlalu_widen #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_widen_a (
        .src    (src_a),
        .hi_sel (widen_hi),
        .sx     (widen_sx),
        .word   (wd_a)
    );

    dlalu_widen #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_widen_b (
        .src    (src_b),
        .hi_sel (widen_hi),
        .sx     (widen_sx),
        .word   (wd_b)
    );

    // Saturating narrowing paths.
    logic [WORD_W-1:0]    nr_u8;
    logic [FLAG_W-1:0]    nr_u8_clip;
    logic [WORD_W-1:0]    nr_s;
    logic [NUM_LANES-1:0] nr_s_clip;

    dlalu_narrow #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_narrow (
        .a       (src_a),
        .b       (src_b),
        .u8_word (nr_u8),
        .u8_clip (nr_u8_clip),
        .s_word  (nr_s),
        .s_clip  (nr_s_clip)
    );

    logic [WORD_W-1:0] nxt_lo;
    logic [WORD_W-1:0] nxt_hi;
    logic [FLAG_W-1:0] nxt_flags;

    // Result and flag selection by opcode; undefined codes give zero.
    always_comb begin
        nxt_lo    = '0;
        nxt_hi    = '0;
        nxt_flags = '0;
        case (op)
            OP_AS_WORD, OP_AS_WORD_SAT: begin
                nxt_lo               = w_sum;
                nxt_hi               = w_diff;
                nxt_flags[0]         = w_sclip;
                nxt_flags[NUM_LANES] = w_dclip;
            end
            OP_AS_LANE, OP_AS_LANE_SAT: begin
                nxt_lo    = l_sum;
                nxt_hi    = l_diff;
                nxt_flags = {l_dclip, l_sclip};
            end
            OP_MINMAX: begin
                nxt_lo = mm_min;
                nxt_hi = mm_max;
            end
            OP_WIDEN_LO_Z, OP_WIDEN_LO_S, OP_WIDEN_HI_Z, OP_WIDEN_HI_S: begin
                nxt_lo = wd_a;
                nxt_hi = wd_b;
            end
            OP_PACK_U8: begin
                nxt_lo    = nr_u8;
                nxt_flags = nr_u8_clip;
            end
            OP_PACK_S16: begin
                nxt_lo               = nr_s;
                nxt_flags[NUM_LANES-1:0] = nr_s_clip;
            end
            default: begin
                nxt_lo    = '0;
                nxt_hi    = '0;
                nxt_flags = '0;
            end
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            sat_flags <= '0;
        end else begin
            result    <= {nxt_hi, nxt_lo};
            sat_flags <= nxt_flags;
        end
    end

endmodule

// File: rtl/dlalu_chk.sv
// Module: dlalu_chk
// Checker for dual_lane_alu, attached by bind. It relates the opcode
// sampled at one edge to the registered outputs at the next edge.
module dlalu_chk #(
    parameter int LANE_W    = 16,
    parameter int NUM_LANES = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [3:0]                    op_code,
    input logic [2*LANE_W*NUM_LANES-1:0] result,
    input logic [2*NUM_LANES-1:0]        sat_flags
);

    localparam int WORD_W = LANE_W * NUM_LANES;
    localparam int BYTE_W = LANE_W / 2;

    // R2 and R4: wrapping add/subtract never reports a clamp.
    assert_wrap_flagfree_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 || op_code == 4'd2) |=> (sat_flags == '0))
        else $error("wrapping add/subtract raised a clip flag");

    // R3: a flagged word sum sits on one of the two signed rails.
    assert_word_rail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1) |=> (!sat_flags[0]
            || result[WORD_W-1:0] == {1'b0, {(WORD_W-1){1'b1}}}
            || result[WORD_W-1:0] == {1'b1, {(WORD_W-1){1'b0}}}))
        else $error("clamped word sum is not a rail value");

    // R8: the unsigned byte pack leaves the upper word clear.
    assert_pack_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd9) |=> (result[2*WORD_W-1:WORD_W] == '0))
        else $error("byte pack wrote the upper word");

    // R10: undefined opcodes give all-zero outputs.
    assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 4'd10) |=> (result == '0 && sat_flags == '0))
        else $error("undefined opcode produced nonzero output");

    for (genvar i = 0; i < 2*NUM_LANES; i++) begin : g_lane_chk
        // R7: zero-extending widen leaves the upper byte of every lane clear.
        assert_widen_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 4'd5 || op_code == 4'd7) |=> (result[i*LANE_W+BYTE_W +: BYTE_W] == '0))
            else $error("zero-extended lane has a nonzero upper byte");
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_mm_chk
        // R6: each lane minimum is not greater than the lane maximum.
        assert_min_le_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 4'd4) |=> ($signed(result[i*LANE_W +: LANE_W])
                                   <= $signed(result[WORD_W+i*LANE_W +: LANE_W])))
            else $error("lane minimum exceeds lane maximum");
    end

endmodule

bind dual_lane_alu dlalu_chk #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .result    (result),
    .sat_flags (sat_flags)
);

// File: tb/sim_dual_lane_alu.sv
// Bench for dual_lane_alu: sweeps lane boundary values over every opcode
// and compares against an arithmetic model written from the requirements.
module sim_dual_lane_alu;

    logic        clk;
    logic        rst_n;
    logic [3:0]  op_code;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic [63:0] result;
    logic [3:0]  sat_flags;

    int n_checks;
    int n_fail;
    bit done;

    dual_lane_alu u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .result    (result),
        .sat_flags (sat_flags)
    );

    // 250 MHz clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Clamp to a signed 16-bit lane: {clipped, value}.
    function automatic logic [16:0] clamp16(longint v);
        if (v > 32767)  return {1'b1, 16'h7FFF};
        if (v < -32768) return {1'b1, 16'h8000};
        return {1'b0, v[15:0]};
    endfunction

    // Clamp to a signed 32-bit word: {clipped, value}.
    function automatic logic [32:0] clamp32(longint v);
        if (v > 64'sd2147483647)  return {1'b1, 32'h7FFFFFFF};
        if (v < -64'sd2147483648) return {1'b1, 32'h80000000};
        return {1'b0, v[31:0]};
    endfunction

    // Clamp to an unsigned byte: {clipped, value}.
    function automatic logic [8:0] clampu8(longint v);
        if (v < 0)   return {1'b1, 8'h00};
        if (v > 255) return {1'b1, 8'hFF};
        return {1'b0, v[7:0]};
    endfunction

    // Expected {flags, result} for one operation.
    function automatic logic [67:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  f;
        logic [32:0] c32;
        logic [16:0] c16;
        logic [8:0]  c8;
        logic [15:0] ha;
        logic [15:0] hb;
        longint      x;
        longint      y;
        lo = '0; hi = '0; f = '0;
        case (op)
            4'd0: begin lo = a + b; hi = a - b; end
            4'd1: begin
                x = longint'($signed(a)); y = longint'($signed(b));
                c32 = clamp32(x + y); lo = c32[31:0]; f[0] = c32[32];
                c32 = clamp32(x - y); hi = c32[31:0]; f[2] = c32[32];
            end
            4'd2, 4'd3: begin
                for (int i = 0; i < 2; i++) begin
                    x = longint'($signed(a[16*i +: 16])); y = longint'($signed(b[16*i +: 16]));
                    if (op == 4'd2) begin
                        lo[16*i +: 16] = a[16*i +: 16] + b[16*i +: 16];
                        hi[16*i +: 16] = a[16*i +: 16] - b[16*i +: 16];
                    end else begin
                        c16 = clamp16(x + y); lo[16*i +: 16] = c16[15:0]; f[i]   = c16[16];
                        c16 = clamp16(x - y); hi[16*i +: 16] = c16[15:0]; f[2+i] = c16[16];
                    end
                end
            end
            4'd4: begin
                for (int i = 0; i < 2; i++) begin
                    x = longint'($signed(a[16*i +: 16])); y = longint'($signed(b[16*i +: 16]));
                    lo[16*i +: 16] = (x < y) ? a[16*i +: 16] : b[16*i +: 16];
                    hi[16*i +: 16] = (x < y) ? b[16*i +: 16] : a[16*i +: 16];
                end
            end
            4'd5, 4'd6, 4'd7, 4'd8: begin
                ha = (op >= 4'd7) ? a[31:16] : a[15:0];
                hb = (op >= 4'd7) ? b[31:16] : b[15:0];
                if (op == 4'd6 || op == 4'd8) begin
                    lo = {{8{ha[15]}}, ha[15:8], {8{ha[7]}}, ha[7:0]};
                    hi = {{8{hb[15]}}, hb[15:8], {8{hb[7]}}, hb[7:0]};
                end else begin
                    lo = {8'h00, ha[15:8], 8'h00, ha[7:0]};
                    hi = {8'h00, hb[15:8], 8'h00, hb[7:0]};
                end
            end
            4'd9: begin
                for (int k = 0; k < 4; k++) begin
                    x = (k < 2) ? longint'($signed(a[16*k +: 16]))
                                : longint'($signed(b[16*(k-2) +: 16]));
                    c8 = clampu8(x); lo[8*k +: 8] = c8[7:0]; f[k] = c8[8];
                end
            end
            4'd10: begin
                c16 = clamp16(longint'($signed(a))); lo[15:0]  = c16[15:0]; f[0] = c16[16];
                c16 = clamp16(longint'($signed(b))); lo[31:16] = c16[15:0]; f[1] = c16[16];
            end
            default: begin lo = '0; hi = '0; f = '0; end
        endcase
        return {f, hi, lo};
    endfunction

    // Requirement tag for each opcode.
    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6, 4'd7, 4'd8: return "R7";
            4'd9: return "R8";
            4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Compare outputs to the expected pair and count the check.
    task automatic check(string req, logic [63:0] exp_res, logic [3:0] exp_f);
        n_checks++;
        if (result !== exp_res || sat_flags !== exp_f) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h: result=%h flags=%b expected result=%h flags=%b",
                     req, op_code, src_a, src_b, result, sat_flags, exp_res, exp_f);
        end
    endtask

    // Apply one vector at a falling edge and check it one full cycle later.
    task automatic run_vec(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic [67:0] e;
        @(negedge clk);
        op_code = op; src_a = a; src_b = b;
        e = model(op, a, b);
        @(negedge clk);
        check(req_of(op), e[63:0], e[67:64]);
    endtask

    logic [15:0] vals [8];

    initial begin
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h007F; vals[3] = 16'h0080;
        vals[4] = 16'h00FF; vals[5] = 16'h7FFF; vals[6] = 16'h8000; vals[7] = 16'hFFFF;
        n_checks = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; op_code = 4'd0; src_a = 32'h7FFF_0001; src_b = 32'h0001_0001;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset despite active operands.
        check("R1", 64'h0, 4'h0);
        rst_n = 1'b1;
        op_code = 4'd1; src_a = 32'h7FFFFFFF; src_b = 32'h00000001;
        // R1: before the first active edge the registered outputs are still zero.
        #1;
        check("R1", 64'h0, 4'h0);
        @(negedge clk);
        // R1: one edge later the saturated word pair is visible.
        check("R1", {32'h7FFFFFFE, 32'h7FFFFFFF}, 4'b0001);
        for (int op = 0; op < 13; op++) begin
            if (op == 11) continue;
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++)
                        for (int m = 0; m < 8; m++)
                            run_vec(4'(op), {vals[i], vals[j]}, {vals[k], vals[m]});
        end
        // R10: remaining undefined codes with nonzero operands.
        run_vec(4'd11, 32'h8000_7FFF, 32'hFFFF_0001);
        run_vec(4'd15, 32'h1234_5678, 32'h9ABC_DEF0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule